// File: doc/BRIEF.md
# Converter Serial Result Master

This block is the digital output side of a sampling converter that owns its serial link. A one-cycle start pulse launches a conversion, modelled as a fixed count of system clocks, and raises a busy flag. When the count ends, a 16-bit result is captured from a parallel input port. The block then sends results to a host on a serial data line, producing the serial clock itself and a frame-valid strobe that marks the bits as good.

A mode input picks one of two schedules. In read-after mode the fresh result is sent as soon as its conversion ends, and busy stays high until the last bit is out. In read-during mode the frame starts together with a new conversion and carries the result of the conversion before it; busy covers only the conversion. Two polarity inputs invert the serial clock and the strobe separately. A clock-source select input, when high, means that this block must not drive frames; conversions still run and still capture results.

Top module: `adc_serial_master`

## Requirements
- R1: After reset, busy is low, the serial clock sits at its idle level (low when the clock is not inverted, high when it is), the strobe is inactive and the serial data line is low.
- R2: A start pulse seen while busy is low and no frame is running raises busy on the next cycle, and the conversion lasts CONV_CYCLES clocks (default 40). A start pulse during a conversion or a frame is ignored.
- R3: A frame holds 16 bits, most significant bit first. The non-inverted clock gives 16 rising edges, one per CLK_DIV system clocks (default 4), and data changes only at the start of each bit period, half a period before the rising edge.
- R4: With strobe polarity 0 the strobe is high for exactly the length of a frame and low otherwise. With strobe polarity 1 it is low during a frame and high otherwise.
- R5: With clock polarity 1 the serial clock pin is the complement of the non-inverted clock, idle level included, so the host samples on its falling edges.
- R6: Read-after mode (read_during = 0, sampled at start): the frame begins when the conversion ends and carries that conversion's result. Busy stays high for CONV_CYCLES + 16*CLK_DIV clocks without a gap.
- R7: Read-during mode (read_during = 1, sampled at start): the frame begins on the cycle the conversion begins and carries the result captured at the end of the previous conversion. Busy is high for exactly CONV_CYCLES clocks.
- R8: The first read-during frame after reset carries 0x0000.
- R9: With ext_clk_sel = 1 at start, no frame is sent. The clock stays idle, the strobe stays inactive and busy lasts CONV_CYCLES clocks, but the result is still captured for a later read-during frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion start pulse |
| ext_clk_sel | input | 1 | 1: serial clock is external; block sends no frames |
| read_during | input | 1 | 0: read after conversion, 1: read previous during conversion |
| inv_sclk | input | 1 | Inverts the serial clock pin |
| inv_strobe | input | 1 | Inverts the frame-valid strobe pin |
| result_in | input | 16 | Parallel conversion result, captured at conversion end |
| busy | output | 1 | Conversion (and, in read-after mode, frame) in progress |
| sclk | output | 1 | Serial clock to the host |
| sdata | output | 1 | Serial data, MSB first |
| frame_valid | output | 1 | Strobe marking valid serial data |

## Verification
The assertions assume that mode and clock-source select only matter on the cycle a start is accepted. They also assume that start is a single-cycle pulse whose effect shows one cycle later. The polarity inputs go straight to the pins, so they are taken to change only while no frame is running. The bench changes polarity, mode and result only between frames, after busy and the strobe have both gone idle. It also sends an extra start in the middle of a conversion, to exercise the ignore rule within these limits.

// File: rtl/adc_sm_pkg.sv
// Shared types for the converter serial master.
package adc_sm_pkg;
    // Read schedule, latched when a conversion is accepted.
    typedef enum logic {
        RD_AFTER  = 1'b0,
        RD_DURING = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/adc_conv_timer.sv
// Conversion phase timer.
// Assumes: launch is a single-cycle pulse and is only raised while idle.
// Stays in the converting state for CONV_CYCLES clocks after launch, and
// pulses done on the last of them.
module adc_conv_timer #(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic converting,
    output logic done
);
    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] remain_q;

    // Load the count on launch and run it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            converting <= 1'b0;
            remain_q   <= '0;
        end else if (launch) begin
            converting <= 1'b1;
            remain_q   <= CNT_LAST;
        end else if (converting) begin
            if (remain_q == '0) converting <= 1'b0;
            else                remain_q   <= remain_q - 1'b1;
        end
    end

    assign done = converting && (remain_q == '0);

    // A conversion only begins in response to a launch (R2).
    assert_conv_needs_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converting) |-> $past(launch));
endmodule

// File: rtl/adc_frame_shifter.sv
// Serial frame generator.
// Assumes: load only arrives while no frame is active.
// Shifts out DATA_W bits MSB first. Each bit lasts CLK_DIV clocks; the raw
// clock is low for the first half of each bit and high for the second half.
module adc_frame_shifter #(
    parameter int DATA_W  = 16,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    output logic              active,
    output logic              sclk_raw,
    output logic              sdata
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLK_DIV / 2);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg_q;

    // Run the bit-period divider and shift one bit at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else if (load) begin
            active  <= 1'b1;
            div_q   <= '0;
            bit_q   <= '0;
            shreg_q <= load_word;
        end else if (active) begin
            if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (bit_q == BIT_LAST) begin
                    active <= 1'b0;
                end else begin
                    bit_q   <= bit_q + 1'b1;
                    shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sclk_raw = active && (div_q >= DIV_HALF);
    assign sdata    = active && shreg_q[DATA_W-1];

    // A frame ends only after its last bit period (R3).
    assert_frame_full_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(bit_q) == BIT_LAST && $past(div_q) == DIV_LAST));
endmodule

// File: rtl/adc_serial_master.sv
// Converter master serial output controller (top).
// Assumes: start is a pulse; the polarity inputs change only between frames.
// Latches the mode and the clock source when a start is accepted, times the
// conversion, captures result_in at its end and schedules the serial frame.
module adc_serial_master #(
    parameter int DATA_W      = 16,
    parameter int CLK_DIV     = 4,
    parameter int CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ext_clk_sel,
    input  logic              read_during,
    input  logic              inv_sclk,
    input  logic              inv_strobe,
    input  logic [DATA_W-1:0] result_in,
    output logic              busy,
    output logic              sclk,
    output logic              sdata,
    output logic              frame_valid
);
    import adc_sm_pkg::*;

    logic              converting;
    logic              conv_done;
    logic              act;
    logic              sclk_raw;
    logic              accept;
    logic              frame_load;
    logic [DATA_W-1:0] frame_word;
    logic [DATA_W-1:0] result_q;
    rd_mode_e          mode_q;
    logic              ext_q;

    assign accept = start && !converting && !act;

    // Latch the schedule settings for the accepted conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RD_AFTER;
            ext_q  <= 1'b0;
        end else if (accept) begin
            mode_q <= rd_mode_e'(read_during);
            ext_q  <= ext_clk_sel;
        end
    end

    // Keep the most recent result for the next read-during frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         result_q <= '0;
        else if (conv_done) result_q <= result_in;
    end

    // Start a frame with the stored word at launch, or with the fresh one at the end.
    always_comb begin
        frame_load = 1'b0;
        frame_word = result_q;
        if (accept && read_during && !ext_clk_sel) begin
            frame_load = 1'b1;
        end else if (conv_done && mode_q == RD_AFTER && !ext_q) begin
            frame_load = 1'b1;
            frame_word = result_in;
        end
    end

    adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (accept),
        .converting (converting),
        .done       (conv_done)
    );

    adc_frame_shifter #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_load),
        .load_word (frame_word),
        .active    (act),
        .sclk_raw  (sclk_raw),
        .sdata     (sdata)
    );

    assign busy        = converting || (act && mode_q == RD_AFTER);
    assign sclk        = sclk_raw ^ inv_sclk;
    assign frame_valid = act ^ inv_strobe;

    // Read-during frames begin together with their conversion (R7).
    assert_during_frame_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act) && mode_q == RD_DURING) |-> $rose(converting));

    // Read-after frames begin exactly as the conversion ends (R6).
    assert_after_frame_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act) && mode_q == RD_AFTER) |-> $fell(converting));

    // No frame is driven while the clock source is external (R9).
    assert_no_frame_external_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_q && converting) |-> !act);
endmodule

// File: tb/adc_serial_master_tb.sv
// Directed bench: a host model receives frames on the active edge while the
// strobe is active, and measures the busy width.
module adc_serial_master_tb_top;
    localparam int CONV = 40;
    localparam int DIV  = 4;
    localparam int BUSY_AFTER = CONV + 16 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, ext_clk_sel = 1'b0, read_during = 1'b0;
    logic inv_sclk = 1'b0, inv_strobe = 1'b0;
    logic [15:0] result_in = '0;
    logic busy, sclk, sdata, frame_valid;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    adc_serial_master #(.DATA_W(16), .CLK_DIV(DIV), .CONV_CYCLES(CONV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_clk_sel(ext_clk_sel),
        .read_during(read_during), .inv_sclk(inv_sclk), .inv_strobe(inv_strobe),
        .result_in(result_in), .busy(busy), .sclk(sclk), .sdata(sdata),
        .frame_valid(frame_valid)
    );

    // Host model state.
    logic        prev_raw = 1'b0, prev_act = 1'b0;
    logic [15:0] rx_sh = '0, rx_word = '0;
    int          rx_n = 0, rx_bits = 0, frames = 0;
    int          bw = 0, last_bw = 0, busy_falls = 0;

    // Receive bits on the effective rising edge and time busy, away from clk edges.
    always @(negedge clk) begin
        logic raw, act_now;
        raw     = sclk ^ inv_sclk;
        act_now = (frame_valid != inv_strobe);
        if (act_now && !prev_act) begin
            rx_n  = 0;
            rx_sh = '0;
        end
        if (act_now && raw && !prev_raw) begin
            rx_sh = {rx_sh[14:0], sdata};
            rx_n++;
        end
        if (!act_now && prev_act) begin
            rx_word = rx_sh;
            rx_bits = rx_n;
            frames++;
        end
        if (busy) bw++;
        else if (bw != 0) begin
            last_bw = bw;
            bw = 0;
            busy_falls++;
        end
        prev_raw = raw;
        prev_act = act_now;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive_start();
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || (frame_valid != inv_strobe));
        repeat (3) @(negedge clk);
    endtask

    task automatic idle_levels(input string req);
        @(negedge clk);
        chk(req, int'(sclk), int'(inv_sclk));
        chk(req, int'(frame_valid), int'(inv_strobe));
    endtask

    // One conversion with host reception; checks word, bit count and busy width.
    task automatic run_conv(input logic during, input logic [15:0] word,
                            input logic [15:0] exp_word, input int exp_bw,
                            input string req);
        int f0;
        f0 = frames;
        @(posedge clk); #2 read_during = during; result_in = word;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        @(negedge clk);
        chk("R2 busy rises after start", int'(busy), 1);
        wait_idle();
        chk({req, " word"}, int'(rx_word), int'(exp_word));
        chk("R3 bit count", rx_bits, 16);
        chk({req, " busy width"}, last_bw, exp_bw);
        chk({req, " one frame"}, frames - f0, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 sclk idle", int'(sclk), 0);
        chk("R1 strobe", int'(frame_valid), 0);
        chk("R1 sdata", int'(sdata), 0);
    endtask

    task automatic t_during();
        run_conv(1'b1, 16'h1234, 16'h0000, CONV, "R8 first during frame");
        run_conv(1'b1, 16'hBEEF, 16'h1234, CONV, "R7 previous result");
    endtask

    task automatic t_after_polarities();
        for (int p = 0; p < 4; p++) begin
            @(posedge clk); #2 inv_sclk = p[0]; inv_strobe = p[1];
            idle_levels("R5 R4 idle levels");
            run_conv(1'b0, 16'h8001 ^ 16'(p * 16'h1111), 16'h8001 ^ 16'(p * 16'h1111),
                     BUSY_AFTER, "R6 R5 R4 after mode");
        end
        @(posedge clk); #2 inv_sclk = 1'b0; inv_strobe = 1'b0;
    endtask

    task automatic t_ignored_start();
        int f0;
        f0 = frames;
        @(posedge clk); #2 read_during = 1'b0; result_in = 16'hC3A5;
        drive_start();
        repeat (10) @(posedge clk);
        #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        repeat (CONV + 10) @(posedge clk);
        #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        wait_idle();
        chk("R2 ignored start busy width", last_bw, BUSY_AFTER);
        chk("R2 ignored start frames", frames - f0, 1);
        chk("R2 word", int'(rx_word), 16'hC3A5);
    endtask

    task automatic t_external();
        int f0, edges;
        logic last;
        f0 = frames;
        edges = 0;
        @(posedge clk); #2 ext_clk_sel = 1'b1; read_during = 1'b0; result_in = 16'h5A5A;
        drive_start();
        last = sclk;
        for (int i = 0; i < BUSY_AFTER + 8; i++) begin
            @(negedge clk);
            if (sclk != last) edges++;
            last = sclk;
        end
        chk("R9 no clock edges", edges, 0);
        chk("R9 no frame", frames - f0, 0);
        chk("R9 busy width", last_bw, CONV);
        @(posedge clk); #2 ext_clk_sel = 1'b0;
        run_conv(1'b1, 16'h0F0F, 16'h5A5A, CONV, "R9 result captured");
    endtask

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_during();
        t_after_polarities();
        t_ignored_start();
        t_external();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule